// File: doc/BRIEF.md
# Banked Interrupt Flag Controller

This block collects up to 64 interrupt inputs into two banks of 32 and folds them into a single interrupt request for a processor. Each bank offers four 32-bit registers on a plain register bus: latched event flags, enable mask, acknowledge and live input level. A rising edge on an input is synchronised and, if that input is already enabled, sets its event flag. The request output stays high while any enabled flag is pending. Software clears flags by writing ones to the acknowledge register.

Enabling an input whose line is already high does not create a flag and does not raise the request. Software that unmasks such an input must read the level register and start its handler itself. Each input can be marked as level type. For such an input, an acknowledge arriving while the line is still high and enabled sets the flag again, so the request is not dropped.

Top module: `irqflag_ctrl`

## Requirements
- R1: After synchronous reset every event flag and every enable bit is zero and irq is low.
- R2: Word addresses (byte address bits [1:0] must be zero) decode as follows. Sources 0..31 use the bank at 0x20 and sources 32..63 use the bank at 0x10. Within a bank, event is at +0x0, enable at +0x4, ack at +0x8 and level at +0xC. Source n is bit n mod 32 of its bank. Reads of ack return zero. Reads of any other address, or of a misaligned address, return zero. Read data appears on rd_data one clock after the rd_en cycle and holds until the next read.
- R3: A read of an enable register returns the value most recently written to it.
- R4: The event flag of a source is set when a rising edge of its input passes through a two-flop synchronizer. The enable bit must already be one in the clock when the edge is detected. The flag becomes readable three clocks after the input rises.
- R5: Setting an enable bit while that source's input is already high sets no event flag and raises no irq.
- R6: A write to an ack register clears every event flag whose write-data bit is one. Flags whose bit is zero are unchanged.
- R7: irq is a register. It is high one clock after a cycle in which any bank has an event flag and its enable bit both set, and low one clock after a cycle in which none does.
- R8: If an edge sets a flag in the same clock that an ack write clears it, the flag ends up set.
- R9: Writes to event and level registers change nothing.
- R10: A level register reads the synchronised input state, which follows the input pin two clocks later.
- R11: For a source whose src_level bit is one, an ack write has no effect on its flag while its synchronised input is high and its enable bit is one. Once the input is low, the ack clears the flag.
- R12: Clearing an enable bit drops irq for that source but leaves its event flag readable as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte address within the 0x40 window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| src_in | input | 64 | Interrupt source inputs |
| src_level | input | 64 | Per-source type, 1 = level, 0 = edge |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is an edge detection and an acknowledge write that fall in the same clock. It happens only when the ack is sampled on the third edge after the input rises. The stimulus counts falling edges from the moment it raises the input and drives the ack on exactly that clock. The level-type acknowledge also needs care, since the line has to be held high through the ack and then dropped before a second ack. A behavioural model that runs every clock checks both irq and read data at each falling edge, so an off-by-one in the synchronizer depth shows up at once.

// File: rtl/irqflag_pkg.sv
package irqflag_pkg;

    localparam int unsigned WIN_ADDR_W = 6;

    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     aligned;
        reg_sel_e sel;
    } reg_dec_t;

    // bank 0 sits at 0x20, each later bank 0x10 lower
    function automatic logic [WIN_ADDR_W-1:0] bank_base(input int unsigned b);
        return WIN_ADDR_W'(32 - 16 * b);
    endfunction

    function automatic reg_dec_t decode_reg(input logic [WIN_ADDR_W-1:0] a);
        reg_dec_t d;
        d.aligned = (a[1:0] == 2'b00);
        d.sel     = reg_sel_e'(a[3:2]);
        return d;
    endfunction

endpackage

// File: rtl/irqflag_sync.sv
module irqflag_sync #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] stage1_q, stage2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign level = stage2_q;
    assign rise  = stage2_q & ~prev_q;

    // R10: synchronised level follows the pin with two stages of delay
    assert_level_delay_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) == 1'b0 |=> level == $past(stage1_q));

endmodule

// File: rtl/irqflag_bank.sv
module irqflag_bank #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise,
    input  logic [WIDTH-1:0] lvl_type,
    input  logic             en_we,
    input  logic             ack_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] event_q,
    output logic [WIDTH-1:0] enable_q,
    output logic             pending
);
    logic [WIDTH-1:0] ack_mask, set_vec, event_d;

    always_comb begin
        ack_mask = ack_we ? wdata : '0;
        // edge sets, or a level-type ack while still high re-arms the flag
        set_vec  = enable_q & (rise | (lvl_type & level & ack_mask));
        event_d  = (event_q & ~ack_mask) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            event_q  <= '0;
            enable_q <= '0;
        end else begin
            event_q <= event_d;
            if (en_we) begin
                enable_q <= wdata;
            end
        end
    end

    assign pending = |(event_q & enable_q);

    // R4: a flag only appears where the enable was already set
    assert_set_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((event_q & ~$past(event_q) & ~$past(enable_q)) == '0));

    // R6: a flag only disappears where an ack one was written
    assert_clear_needs_ack_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~event_q & $past(event_q) & ~$past(ack_mask)) == '0));

    // R8: a set in the same clock as an ack leaves the flag set
    assert_set_beats_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((event_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/irqflag_ctrl.sv
module irqflag_ctrl
    import irqflag_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned BANK_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WIN_ADDR_W-1:0] addr,
    input  logic                  wr_en,
    input  logic [BANK_W-1:0]     wr_data,
    input  logic                  rd_en,
    output logic [BANK_W-1:0]     rd_data,
    input  logic [NUM_SRC-1:0]    src_in,
    input  logic [NUM_SRC-1:0]    src_level,
    output logic                  irq
);
    localparam int unsigned NUM_BANKS = NUM_SRC / BANK_W;

    reg_dec_t            dec;
    logic [NUM_SRC-1:0]  sync_lvl, sync_rise;
    logic [NUM_BANKS-1:0] bank_hit, bank_pend;
    logic [BANK_W-1:0]   ev_arr [NUM_BANKS];
    logic [BANK_W-1:0]   en_arr [NUM_BANKS];
    logic [BANK_W-1:0]   rd_word, rd_q;
    logic                irq_q;

    assign dec = decode_reg(addr);

    irqflag_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (src_in),
        .level (sync_lvl),
        .rise  (sync_rise)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [WIN_ADDR_W-1:0] BASE = bank_base(b);
        logic en_we_b, ack_we_b;

        assign bank_hit[b] = dec.aligned && (addr[WIN_ADDR_W-1:4] == BASE[WIN_ADDR_W-1:4]);
        assign en_we_b     = wr_en && bank_hit[b] && (dec.sel == REG_ENABLE);
        assign ack_we_b    = wr_en && bank_hit[b] && (dec.sel == REG_ACK);

        irqflag_bank #(.WIDTH(BANK_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .level    (sync_lvl[b*BANK_W +: BANK_W]),
            .rise     (sync_rise[b*BANK_W +: BANK_W]),
            .lvl_type (src_level[b*BANK_W +: BANK_W]),
            .en_we    (en_we_b),
            .ack_we   (ack_we_b),
            .wdata    (wr_data),
            .event_q  (ev_arr[b]),
            .enable_q (en_arr[b]),
            .pending  (bank_pend[b])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                unique case (dec.sel)
                    REG_EVENT:  rd_word = ev_arr[b];
                    REG_ENABLE: rd_word = en_arr[b];
                    REG_LEVEL:  rd_word = sync_lvl[b*BANK_W +: BANK_W];
                    default:    rd_word = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (rd_en) begin
                rd_q <= rd_word;
            end
            irq_q <= |bank_pend;
        end
    end

    assign rd_data = rd_q;
    assign irq     = irq_q;

    // R7: request follows any pending bank by one clock
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
        (|bank_pend) |=> irq);
    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (rst)
        !(|bank_pend) |=> !irq);

    // R2: ack and out-of-window reads return zero
    assert_ack_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.sel == REG_ACK) |=> rd_data == '0);
    assert_miss_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bank_hit == '0) |=> rd_data == '0);

    // R1: reset leaves the request low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

// File: tb/irqflag_ctrl_test.sv
`timescale 1ns/1ps
module irqflag_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [63:0] src_in = '0;
    logic [63:0] src_level = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irqflag_ctrl uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .src_in(src_in), .src_level(src_level),
        .irq(irq)
    );

    // behavioural reference, one step per clock
    logic [63:0] m_s1, m_s2, m_prev, m_ev, m_en;
    logic [31:0] m_rd;
    logic        m_irq;

    function automatic logic [31:0] m_read(input logic [5:0] a);
        int lo;
        if (a[1:0] != 2'b00) return 32'h0;
        if (a[5:4] == 2'b10) lo = 0;
        else if (a[5:4] == 2'b01) lo = 32;
        else return 32'h0;
        case (a[3:2])
            2'd0: return m_ev[lo +: 32];
            2'd1: return m_en[lo +: 32];
            2'd3: return m_s2[lo +: 32];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [63:0] rise_m, ack_m, set_m;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_ev = '0; m_en = '0;
            m_rd = '0; m_irq = 1'b0;
        end else begin
            rise_m = m_s2 & ~m_prev;
            ack_m  = '0;
            if (wr_en && addr[1:0] == 2'b00 && addr[3:2] == 2'd2) begin
                if (addr[5:4] == 2'b10) ack_m[31:0] = wr_data;
                else if (addr[5:4] == 2'b01) ack_m[63:32] = wr_data;
            end
            set_m = m_en & (rise_m | (src_level & m_s2 & ack_m));
            if (rd_en) m_rd = m_read(addr);
            m_irq = |(m_ev & m_en);
            m_ev  = (m_ev & ~ack_m) | set_m;
            if (wr_en && addr[1:0] == 2'b00 && addr[3:2] == 2'd1) begin
                if (addr[5:4] == 2'b10) m_en[31:0] = wr_data;
                else if (addr[5:4] == 2'b01) m_en[63:32] = wr_data;
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = src_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live && !rst) begin
            check("R7 irq vs model", {31'b0, irq}, {31'b0, m_irq});
            check("R2 rd_data vs model", rd_data, m_rd);
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(6'h24, v); check("R1 enable bank0 reset", v, 32'h0);
        rd(6'h20, v); check("R1 event bank0 reset", v, 32'h0);

        wr(6'h24, 32'h0000_0001);
        wr(6'h14, 32'h8000_0000);
        rd(6'h24, v); check("R3 enable bank0 readback", v, 32'h0000_0001);
        rd(6'h14, v); check("R3 enable bank1 readback", v, 32'h8000_0000);

        // R4 and R7: source 0 edge
        src_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(6'h20, v); check("R4 flag not yet visible", v, 32'h0);
        @(negedge clk);
        check("R7 irq one clock after flag", {31'b0, irq}, 32'h1);
        rd(6'h20, v); check("R4 event bit0 set", v, 32'h0000_0001);

        // R6: zero bits leave the flag, one bit clears it
        wr(6'h28, 32'hFFFF_FFFE);
        rd(6'h20, v); check("R6 zero bit no effect", v, 32'h0000_0001);
        wr(6'h28, 32'h0000_0001);
        rd(6'h20, v); check("R6 one bit clears", v, 32'h0);
        check("R7 irq low after clear", {31'b0, irq}, 32'h0);

        // R5: enable an already-high source
        src_in[5] = 1'b1;
        repeat (4) @(negedge clk);
        wr(6'h24, 32'h0000_0021);
        repeat (4) @(negedge clk);
        rd(6'h20, v); check("R5 no flag from enable", v, 32'h0);
        check("R5 no irq from enable", {31'b0, irq}, 32'h0);

        // R9 and R10
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h2C, 32'h0000_0000);
        rd(6'h20, v); check("R9 event write ignored", v, 32'h0);
        rd(6'h2C, v); check("R9 R10 level reads pins", v, 32'h0000_0021);

        // R2: bank1 mapping and zero reads
        src_in[63] = 1'b1;
        @(negedge clk);
        rd(6'h1C, v); check("R10 level after one clock", v, 32'h0);
        rd(6'h1C, v); check("R10 level after two clocks", v, 32'h8000_0000);
        @(negedge clk);
        rd(6'h10, v); check("R2 source 63 in bank1 bit31", v, 32'h8000_0000);
        rd(6'h20, v); check("R2 bank0 untouched", v, 32'h0);
        rd(6'h18, v); check("R2 ack reads zero", v, 32'h0);
        rd(6'h00, v); check("R2 unmapped reads zero", v, 32'h0);
        rd(6'h11, v); check("R2 misaligned reads zero", v, 32'h0);
        wr(6'h18, 32'h8000_0000);
        rd(6'h10, v); check("R6 bank1 ack", v, 32'h0);

        // R8: ack lands on the set clock
        wr(6'h24, 32'h0000_0023);
        src_in[1] = 1'b1;
        @(negedge clk); @(negedge clk);
        wr(6'h28, 32'h0000_0002);
        rd(6'h20, v); check("R8 set wins over ack", v, 32'h0000_0002);

        // R11: level-type ack while high
        src_level[2] = 1'b1;
        wr(6'h24, 32'h0000_0027);
        src_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        rd(6'h20, v); check("R11 level source flagged", v, 32'h0000_0006);
        wr(6'h28, 32'h0000_0004);
        rd(6'h20, v); check("R11 ack ignored while high", v, 32'h0000_0006);
        src_in[2] = 1'b0;
        repeat (3) @(negedge clk);
        wr(6'h28, 32'h0000_0004);
        rd(6'h20, v); check("R11 ack clears when low", v, 32'h0000_0002);

        // R12: masking keeps the flag
        check("R12 irq before mask", {31'b0, irq}, 32'h1);
        wr(6'h24, 32'h0000_0021);
        @(negedge clk);
        check("R12 irq dropped", {31'b0, irq}, 32'h0);
        rd(6'h20, v); check("R12 flag kept", v, 32'h0000_0002);

        // R1: reset again clears state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(6'h24, v); check("R1 enable cleared by reset", v, 32'h0);
        rd(6'h20, v); check("R1 event cleared by reset", v, 32'h0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule